// File: doc/BRIEF.md
# Seconds Counter and Periodic Interrupt Timer

This block combines two timing functions behind one 16-bit register bus. A 33-bit seconds counter advances on every cycle where the seconds tick input is high. Software reads it through three registers. The lowest register holds only the count's least significant bit, placed in its top bit position. The other two registers each hold sixteen further bits.

The second function is a periodic interrupt generator. A reference tick input supplies the base rate. Software writes a divisor N into the period register, and from then on every N reference ticks is one expired period. Expired periods gather in a saturating pending counter. The interrupt output goes high on a reference tick while the counter is nonzero. Any access to the acknowledge register lowers the interrupt and retires one pending period. Pending periods left after an acknowledge raise the interrupt again on the next reference tick.

The bus is a plain one-cycle strobe with no back-pressure. A write takes effect at the clock edge where `bus_en` and `bus_we` are high. A read captures `bus_rdata` at the edge where `bus_en` is high and `bus_we` is low, and holds it until the next read.

Top module: `tick_period_timer`

## Requirements
- R1: After reset the seconds count is zero, the period register reads 0, the pending count is zero and `irq` is low. No period expires, whatever the reference ticks, until a nonzero period is written.
- R2: Each clock edge with `sec_tick` high adds one to the 33-bit seconds count. A read of offset 0xC0 returns count bit 0 in data bit 15, and zero in bits 14..0.
- R3: A read of offset 0xC2 returns count bits 16..1 in data bits 15..0. A read of offset 0xC4 returns count bits 32..17 in data bits 15..0.
- R4: A nonzero write N to offset 0xD0 sets the period. Reads of 0xD0 return N, and every N-th reference tick after the write is one expired period.
- R5: A write of zero to offset 0xD0 leaves the period and the divider running unchanged.
- R6: Every period write restarts the divider, so the next expiry comes N reference ticks after the write.
- R7: Each expired period adds one to the pending count. The count stops at 2^PEND_W-1 (15 by default) and does not wrap.
- R8: `irq` rises one clock after a reference tick on which the pending count, before that cycle's update, was nonzero. It never rises otherwise.
- R9: Any access, read or write, to offset 0xDE drives `irq` low on the next clock. It lowers the pending count by one when the count is nonzero, and leaves a zero count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse at the base rate for the period divider |
| sec_tick | input | 1 | One-cycle pulse each second |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data, registered, valid the clock after a read strobe |
| irq | output | 1 | Periodic interrupt request |

## Verification
A table of period values and reference-tick counts drives the generator. After each entry the bench counts how many acknowledges it takes to drain the interrupt. The entries cover an exact multiple of the period, a remainder, fewer ticks than one period, and enough expiries to reach saturation. Together they separate correct division from off-by-one divider limits and from a counter that wraps. Directed cases check the rest:
- the tick on which `irq` first rises, which tells a registered pending check from a combinational one;
- a divider restart by rewriting the period;
- a zero write;
- an acknowledge by read access;
- an acknowledge at zero.

The seconds registers are read after a few ticks, and again after a run long enough to carry into the top register, which tells the uneven bit split from an even one.

// File: rtl/tpt_pkg.sv
package tpt_pkg;
  // Register byte offsets; the three seconds registers hold adjacent bit slices.
  localparam logic [7:0] OFS_SEC_BIT0 = 8'hC0;
  localparam logic [7:0] OFS_SEC_MID  = 8'hC2;
  localparam logic [7:0] OFS_SEC_TOP  = 8'hC4;
  localparam logic [7:0] OFS_PERIOD   = 8'hD0;
  localparam logic [7:0] OFS_ACK      = 8'hDE;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SEC_BIT0,
    SEL_SEC_MID,
    SEL_SEC_TOP,
    SEL_PERIOD,
    SEL_ACK
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [7:0] ofs);
    case (ofs)
      OFS_SEC_BIT0: decode = SEL_SEC_BIT0;
      OFS_SEC_MID:  decode = SEL_SEC_MID;
      OFS_SEC_TOP:  decode = SEL_SEC_TOP;
      OFS_PERIOD:   decode = SEL_PERIOD;
      OFS_ACK:      decode = SEL_ACK;
      default:      decode = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/tpt_sec_count.sv
module tpt_sec_count #(
  parameter int SEC_W = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  output logic [SEC_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)        count <= '0;
    else if (sec_tick) count <= count + SEC_W'(1);
  end
endmodule

// File: rtl/tpt_divider.sv
module tpt_divider #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] period,
  output logic [DATA_W-1:0] phase,
  output logic              expire
);
  logic running;
  logic at_last;

  assign running = (period != '0);
  assign at_last = (phase == period - DATA_W'(1));
  // A write in the same cycle wins over the tick, so the new period starts clean.
  assign expire  = running && ref_tick && !load && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period <= '0;
      phase  <= '0;
    end else if (load) begin
      period <= load_val;
      phase  <= '0;
    end else if (running && ref_tick) begin
      phase <= at_last ? '0 : phase + DATA_W'(1);
    end
  end
endmodule

// File: rtl/tpt_pending.sv
module tpt_pending #(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              ack,
  input  logic              ref_tick,
  output logic [PEND_W-1:0] pend,
  output logic              irq
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic inc, dec;
  assign inc = expire && (pend != PEND_MAX);
  assign dec = ack && (pend != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   pend <= pend + PEND_W'(1);
        2'b01:   pend <= pend - PEND_W'(1);
        default: pend <= pend;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       irq <= 1'b0;
    else if (ack)                     irq <= 1'b0;
    else if (ref_tick && pend != '0)  irq <= 1'b1;
  end
endmodule

// File: rtl/tick_period_timer.sv
module tick_period_timer
  import tpt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              sec_tick,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int SEC_W = 2 * DATA_W + 1;

  reg_sel_e           sel;
  logic               period_load;
  logic               ack;
  logic [SEC_W-1:0]   sec_q;
  logic [DATA_W-1:0]  period_q;
  logic [DATA_W-1:0]  phase_q;
  logic               expire;
  logic [PEND_W-1:0]  pend_q;
  logic [DATA_W-1:0]  rd_mux;

  assign sel         = decode(8'(bus_addr));
  assign period_load = bus_en && bus_we && (sel == SEL_PERIOD) && (bus_wdata != '0);
  assign ack         = bus_en && (sel == SEL_ACK);

  tpt_sec_count #(.SEC_W(SEC_W)) u_sec (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .count    (sec_q)
  );

  tpt_divider #(.DATA_W(DATA_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .load     (period_load),
    .load_val (bus_wdata),
    .period   (period_q),
    .phase    (phase_q),
    .expire   (expire)
  );

  tpt_pending #(.PEND_W(PEND_W)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire   (expire),
    .ack      (ack),
    .ref_tick (ref_tick),
    .pend     (pend_q),
    .irq      (irq)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_SEC_BIT0: rd_mux[DATA_W-1] = sec_q[0];
      SEL_SEC_MID:  rd_mux = sec_q[DATA_W:1];
      SEL_SEC_TOP:  rd_mux = sec_q[2*DATA_W:DATA_W+1];
      SEL_PERIOD:   rd_mux = period_q;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/tick_period_timer_chk.sv
module tick_period_timer_chk #(
  parameter int DATA_W = 16,
  parameter int PEND_W = 4,
  parameter int SEC_W  = 33
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_tick,
  input logic              sec_tick,
  input logic              zero_wr,
  input logic              period_load,
  input logic              ack,
  input logic              expire,
  input logic [SEC_W-1:0]  sec_q,
  input logic [DATA_W-1:0] period_q,
  input logic [DATA_W-1:0] phase_q,
  input logic [PEND_W-1:0] pend_q,
  input logic              irq
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  // R2
  sec_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> sec_q == $past(sec_q) + SEC_W'(1));
  // R2
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(sec_q));
  // R5
  zero_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_wr |=> $stable(period_q));
  // R6
  reload_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_load |=> phase_q == '0);
  // R7
  pend_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == PEND_MAX && !ack) |=> pend_q == PEND_MAX);
  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ref_tick) && $past(pend_q) != '0));
  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq);
  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0 && !expire) |=> pend_q == '0);
endmodule

bind tick_period_timer tick_period_timer_chk #(
  .DATA_W(DATA_W), .PEND_W(PEND_W), .SEC_W(SEC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_tick    (ref_tick),
  .sec_tick    (sec_tick),
  .zero_wr     (bus_en && bus_we && (sel == tpt_pkg::SEL_PERIOD) && (bus_wdata == '0)),
  .period_load (period_load),
  .ack         (ack),
  .expire      (expire),
  .sec_q       (sec_q),
  .period_q    (period_q),
  .phase_q     (phase_q),
  .pend_q      (pend_q),
  .irq         (irq)
);

// File: tb/tb_tick_period_timer.sv
module tb_tick_period_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_S0 = 8'hC0, A_S1 = 8'hC2, A_S2 = 8'hC4, A_PER = 8'hD0, A_ACK = 8'hDE;

  // Vector table: period written, reference ticks applied, pending periods expected
  localparam int VEC_N = 6;
  localparam logic [15:0] V_PER [VEC_N] = '{16'd1, 16'd2, 16'd3, 16'd5, 16'd1, 16'd7};
  localparam int          V_TCK [VEC_N] = '{3, 5, 9, 4, 20, 15};
  localparam int          V_EXP [VEC_N] = '{3, 2, 3, 0, 15, 2};

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, sec_tick = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_period_timer dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sec_tick(sec_tick),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk); bus_en = 1'b0; d = bus_rdata;
  endtask

  task automatic ref_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  // Stops expiry with a long period, then counts acknowledges until irq stays low.
  task automatic drain(output int cnt);
    bus_wr(A_PER, 16'hFFFF);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      ref_pulses(1);
      if (!irq) break;
      bus_wr(A_ACK, 16'h0000);
      cnt++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog requirement=none actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq after reset", irq, 0);
    bus_rd(A_S0, rd);  chk("R1 sec bit0 reg", rd, 0);
    bus_rd(A_S1, rd);  chk("R1 sec mid reg", rd, 0);
    bus_rd(A_S2, rd);  chk("R1 sec top reg", rd, 0);
    bus_rd(A_PER, rd); chk("R1 period reg", rd, 0);
    ref_pulses(5);
    chk("R1 no irq while disabled", irq, 0);
    drain(n); chk("R1 no expiry while disabled", n, 0);

    // R4 R7 table of periods and tick counts
    for (int v = 0; v < VEC_N; v++) begin
      bus_wr(A_PER, V_PER[v]);
      bus_rd(A_PER, rd); chk("R4 period readback", rd, V_PER[v]);
      ref_pulses(V_TCK[v]);
      drain(n); chk($sformatf("R4 R7 vector %0d pending", v), n, V_EXP[v]);
    end

    // R8 irq waits for the tick after the first expiry
    bus_wr(A_PER, 16'd1);
    ref_pulses(1); chk("R8 irq low on first expiry tick", irq, 0);
    ref_pulses(1); chk("R8 irq high on next tick", irq, 1);
    drain(n); chk("R8 pending count", n, 2);

    // R6 rewrite restarts divider
    bus_wr(A_PER, 16'd4); ref_pulses(3);
    bus_wr(A_PER, 16'd4); ref_pulses(3);
    drain(n); chk("R6 restart prevents expiry", n, 0);

    // R5 zero write ignored
    bus_wr(A_PER, 16'd3); ref_pulses(2);
    bus_wr(A_PER, 16'd0);
    bus_rd(A_PER, rd); chk("R5 period kept", rd, 3);
    ref_pulses(4);
    drain(n); chk("R5 divider kept running", n, 2);

    // R9 read access acknowledges
    bus_wr(A_PER, 16'd1); ref_pulses(2);
    chk("R9 irq before read ack", irq, 1);
    bus_rd(A_ACK, rd);
    chk("R9 irq cleared by read", irq, 0);
    drain(n); chk("R9 one retired by read", n, 1);

    // R9 ack at zero does not wrap
    bus_wr(A_ACK, 16'h0000);
    chk("R9 irq low after ack at zero", irq, 0);
    bus_wr(A_PER, 16'd2); ref_pulses(2);
    drain(n); chk("R9 no underflow", n, 1);

    // R2 R3 seconds count
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
    bus_rd(A_S0, rd); chk("R2 bit0 of 5", rd, 16'h8000);
    bus_rd(A_S1, rd); chk("R3 mid of 5", rd, 16'h0002);
    bus_rd(A_S2, rd); chk("R3 top of 5", rd, 16'h0000);
    @(negedge clk); sec_tick = 1'b1;
    repeat (131070) @(negedge clk);
    sec_tick = 1'b0;
    // total 131075 = 0x20003
    bus_rd(A_S0, rd); chk("R2 bit0 of 0x20003", rd, 16'h8000);
    bus_rd(A_S1, rd); chk("R3 mid of 0x20003", rd, 16'h0001);
    bus_rd(A_S2, rd); chk("R3 top of 0x20003", rd, 16'h0001);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule